// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block takes two IEEE-754 operands, in either single or double precision, and turns their relation into four condition flags: negative (N), zero (Z), carry (C) and overflow (V). It also keeps a sticky invalid-operation bit. A double-precision operand is supplied as two 32-bit register halves. A single-precision operand uses only the low half. Both results are registered, so they appear one clock after the request strobe. A pipeline issues one compare per strobe and reads the flags together with the valid strobe.

Several controls shape each compare:
- A zero-compare select replaces the second operand with positive zero.
- A signalling-compare select makes every unordered result raise the invalid bit. In quiet mode, only a signalling NaN raises it.
- A flush enable turns denormal inputs into zeros of the same sign before the comparison.

Ordering follows sign and magnitude. The two zeros are treated as equal. Any NaN makes the result unordered.

Top module: `fcmp_flag_unit`

## Requirements
- R1: Equal operands give flags {N,Z,C,V} = 4'b0110.
- R2: First operand less than second gives {N,Z,C,V} = 4'b1000.
- R3: First operand greater than second gives {N,Z,C,V} = 4'b0010.
- R4: If either operand is a NaN (exponent all ones, fraction nonzero), the result is unordered and gives {N,Z,C,V} = 4'b0011.
- R5: With sig_sel=0, inv_op is raised only when an operand is a signalling NaN. A NaN is signalling when its quiet bit is clear: bit 22 in single precision, bit 51 in double precision.
- R6: With sig_sel=1, every unordered result raises inv_op, whether the NaN is quiet or signalling.
- R7: With zero_sel=1, the second operand is +0 and opb_lo/opb_hi have no effect on the flags.
- R8: With ftz_en=1, a denormal operand (exponent zero, fraction nonzero) is replaced by a zero of the same sign before comparing. With ftz_en=0, denormals compare by value.
- R9: In double mode an operand is {x_hi, x_lo}, with x_lo in bits 31:0. In single mode only x_lo is used and x_hi has no effect.
- R10: +0 and -0 compare equal. Between two negative values, the one with the larger magnitude is the smaller value.
- R11: The flags and out_valid update on the clock edge that samples in_valid=1. Without in_valid, out_valid is 0 the next cycle and the flags hold their value.
- R12: Reset clears the flags, out_valid and inv_op. Once set, inv_op stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Compare request strobe |
| dbl_sel | input | 1 | 1 = double precision, 0 = single |
| zero_sel | input | 1 | Compare first operand against +0 |
| sig_sel | input | 1 | Signalling compare: any unordered result is invalid |
| ftz_en | input | 1 | Flush denormal operands to signed zero |
| opa_lo | input | 32 | First operand, low half |
| opa_hi | input | 32 | First operand, high half (double only) |
| opb_lo | input | 32 | Second operand, low half |
| opb_hi | input | 32 | Second operand, high half (double only) |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag (unordered) |
| inv_op | output | 1 | Sticky invalid-operation flag |
| out_valid | output | 1 | Flags updated this cycle |

## Verification
The assertions check the following on every cycle:
- out_valid follows in_valid by exactly one cycle.
- The flags hold when no request arrives.
- The flags always form one of the four legal codes.
- inv_op never drops once set.
- A signalling compare that yields unordered always leaves inv_op set.

Only the bench's scenarios can show the following:
- The actual ordering of values: signed zeros, negative magnitudes, and halves placed in the right positions.
- The difference between quiet and signalling NaNs in quiet mode.
- Denormal flushing.
- Operands that are ignored in zero mode and in single mode.

These are checked against a reference that maps each value to a signed integer.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int HALF_W   = 32;
    localparam int DBL_W    = 2 * HALF_W;
    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;
    localparam int MAG_W    = DP_EXP_W + DP_MAN_W;

    // Sign-magnitude key shared by both precisions
    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             nan;
        logic             snan;
    } fp_key_t;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic nzcv_t rel_to_nzcv(input rel_t r);
        nzcv_t f;
        case (r)
            REL_EQ:  f = '{n: 1'b0, z: 1'b1, c: 1'b1, v: 1'b0};
            REL_LT:  f = '{n: 1'b1, z: 1'b0, c: 1'b0, v: 1'b0};
            REL_GT:  f = '{n: 1'b0, z: 1'b0, c: 1'b1, v: 1'b0};
            default: f = '{n: 1'b0, z: 1'b0, c: 1'b1, v: 1'b1};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/fcmp_field_decode.sv
module fcmp_field_decode
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] word,
    input  logic                 ftz_en,
    output fp_key_t              key
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] frac;
    logic             exp_ones, exp_zero, frac_nz, flush;

    always_comb begin
        expo     = word[W-2 -: EXP_W];
        frac     = word[MAN_W-1:0];
        exp_ones = &expo;
        exp_zero = ~|expo;
        frac_nz  = |frac;
        flush    = ftz_en & exp_zero & frac_nz;   // R8

        key      = '0;
        key.sign = word[W-1];
        key.nan  = exp_ones & frac_nz;            // R4
        key.snan = exp_ones & frac_nz & ~frac[MAN_W-1]; // R5 quiet bit clear
        if (!flush)
            key.mag[EXP_W+MAN_W-1:0] = {expo, frac};
    end
endmodule

// File: rtl/fcmp_operand.sv
module fcmp_operand
    import fcmp_pkg::*;
(
    input  logic              dbl_sel,
    input  logic              ftz_en,
    input  logic              use_zero,
    input  logic [HALF_W-1:0] lo,
    input  logic [HALF_W-1:0] hi,
    output fp_key_t           key
);
    fp_key_t sp_key, dp_key;

    // R9: low half sits in bits 31:0 of the double word
    fcmp_field_decode #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_sp (
        .word(lo), .ftz_en(ftz_en), .key(sp_key)
    );
    fcmp_field_decode #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) u_dp (
        .word({hi, lo}), .ftz_en(ftz_en), .key(dp_key)
    );

    always_comb begin
        if (use_zero)      key = '0;      // R7: +0 constant
        else if (dbl_sel)  key = dp_key;
        else               key = sp_key;
    end
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
    import fcmp_pkg::*;
(
    input  fp_key_t ka,
    input  fp_key_t kb,
    output rel_t    rel
);
    logic both_zero, mag_eq, mag_lt;

    always_comb begin
        both_zero = ~|ka.mag & ~|kb.mag;
        mag_eq    = ka.mag == kb.mag;
        mag_lt    = ka.mag <  kb.mag;

        if (ka.nan | kb.nan)
            rel = REL_UN;
        else if (both_zero)
            rel = REL_EQ;                         // R10 signed zeros
        else if (ka.sign != kb.sign)
            rel = ka.sign ? REL_LT : REL_GT;
        else if (mag_eq)
            rel = REL_EQ;
        else if (ka.sign)
            rel = mag_lt ? REL_GT : REL_LT;       // R10 negative ordering
        else
            rel = mag_lt ? REL_LT : REL_GT;
    end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
    import fcmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        dbl_sel,
    input  logic        zero_sel,
    input  logic        sig_sel,
    input  logic        ftz_en,
    input  logic [31:0] opa_lo,
    input  logic [31:0] opa_hi,
    input  logic [31:0] opb_lo,
    input  logic [31:0] opb_hi,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_c,
    output logic        flag_v,
    output logic        inv_op,
    output logic        out_valid
);
    localparam int NUM_OPS = 2;

    logic [HALF_W-1:0] lo_w   [NUM_OPS];
    logic [HALF_W-1:0] hi_w   [NUM_OPS];
    logic              zero_w [NUM_OPS];
    fp_key_t           key    [NUM_OPS];

    assign lo_w[0] = opa_lo;  assign hi_w[0] = opa_hi;  assign zero_w[0] = 1'b0;
    assign lo_w[1] = opb_lo;  assign hi_w[1] = opb_hi;  assign zero_w[1] = zero_sel;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
        fcmp_operand u_op (
            .dbl_sel (dbl_sel),
            .ftz_en  (ftz_en),
            .use_zero(zero_w[i]),
            .lo      (lo_w[i]),
            .hi      (hi_w[i]),
            .key     (key[i])
        );
    end

    rel_t  rel;
    logic  inv_evt;
    nzcv_t flags_q;
    logic  inv_q, valid_q;

    fcmp_relate u_rel (.ka(key[0]), .kb(key[1]), .rel(rel));

    // R5 / R6
    assign inv_evt = (rel == REL_UN) & (sig_sel | key[0].snan | key[1].snan);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            inv_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                flags_q <= rel_to_nzcv(rel);
                if (inv_evt) inv_q <= 1'b1;
            end
        end
    end

    assign flag_n    = flags_q.n;
    assign flag_z    = flags_q.z;
    assign flag_c    = flags_q.c;
    assign flag_v    = flags_q.v;
    assign inv_op    = inv_q;
    assign out_valid = valid_q;

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R11
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable({flag_n, flag_z, flag_c, flag_v})));

    // R12
    inv_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        inv_op |=> inv_op);

    // R4
    flags_legal_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ({flag_n, flag_z, flag_c, flag_v} inside
                       {4'b0110, 4'b1000, 4'b0010, 4'b0011}));

    // R6
    sig_unord_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sig_sel) |=> (!flag_v || inv_op));
endmodule

// File: tb/tb_fcmp_flag_unit.sv
module tb_fcmp_flag_unit;
    logic        clk = 1'b0;
    logic        rst, in_valid, dbl_sel, zero_sel, sig_sel, ftz_en;
    logic [31:0] opa_lo, opa_hi, opb_lo, opb_hi;
    logic        flag_n, flag_z, flag_c, flag_v, inv_op, out_valid;

    int  n_tests = 0;
    int  n_fail  = 0;
    logic exp_inv = 1'b0;

    always #5 clk = ~clk;

    fcmp_flag_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .dbl_sel(dbl_sel),
        .zero_sel(zero_sel), .sig_sel(sig_sel), .ftz_en(ftz_en),
        .opa_lo(opa_lo), .opa_hi(opa_hi), .opb_lo(opb_lo), .opb_hi(opb_hi),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .inv_op(inv_op), .out_valid(out_valid)
    );

    // Map an operand to NaN class plus a signed integer in value order
    function automatic void decode(input logic dbl, input logic [63:0] w,
                                   input logic ftz, output logic nan,
                                   output logic snan, output longint val);
        logic   sgn;
        longint e, m, mag;
        if (dbl) begin
            sgn = w[63]; e = longint'(w[62:52]); m = longint'(w[51:0]);
            nan  = (e == 2047) && (m != 0);
            snan = nan && !w[51];
            mag  = (e <<< 52) | m;
        end else begin
            sgn = w[31]; e = longint'(w[30:23]); m = longint'(w[22:0]);
            nan  = (e == 255) && (m != 0);
            snan = nan && !w[22];
            mag  = (e <<< 23) | m;
        end
        if (ftz && e == 0 && m != 0) mag = 0;
        val = sgn ? -mag : mag;
    endfunction

    // returns {N,Z,C,V,invalid_event}
    function automatic logic [4:0] ref_cmp(input logic dbl, zs, sg, ftz,
                                           input logic [63:0] a, b);
        logic na, sa, nb, sb;
        longint va, vb;
        decode(dbl, a, ftz, na, sa, va);
        if (zs) begin nb = 0; sb = 0; vb = 0; end
        else decode(dbl, b, ftz, nb, sb, vb);
        if (na || nb)   return {4'b0011, sg | sa | sb};
        if (va == vb)   return {4'b0110, 1'b0};
        if (va < vb)    return {4'b1000, 1'b0};
        return {4'b0010, 1'b0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        exp_inv = 1'b0;
    endtask

    task automatic run(input string tag, input logic dbl, zs, sg, ftz,
                       input logic [31:0] ahi, alo, bhi, blo);
        logic [4:0] r;
        @(negedge clk);
        in_valid = 1'b1; dbl_sel = dbl; zero_sel = zs; sig_sel = sg; ftz_en = ftz;
        opa_hi = ahi; opa_lo = alo; opb_hi = bhi; opb_lo = blo;
        r = ref_cmp(dbl, zs, sg, ftz, {ahi, alo}, {bhi, blo});
        exp_inv = exp_inv | r[0];
        @(posedge clk); #1;
        in_valid = 1'b0;
        check({tag, " flags"}, {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, r[4:1]});
        check({tag, " inv"}, {31'd0, inv_op}, {31'd0, exp_inv});
        check({tag, " valid R11"}, {31'd0, out_valid}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] held;
        void'($urandom(32'h1357));
        rst = 1'b1; in_valid = 0; dbl_sel = 0; zero_sel = 0; sig_sel = 0; ftz_en = 0;
        opa_lo = 0; opa_hi = 0; opb_lo = 0; opb_hi = 0;
        repeat (2) @(posedge clk); #1;
        // R12 reset state
        check("R12 reset", {26'd0, flag_n, flag_z, flag_c, flag_v, inv_op, out_valid}, 32'd0);
        do_reset();

        run("R1 eq sp",      0,0,0,0, 0, 32'h3F800000, 0, 32'h3F800000);
        run("R2 lt sp",      0,0,0,0, 0, 32'h3F800000, 0, 32'h40000000);
        run("R3 gt sp",      0,0,0,0, 0, 32'h40000000, 0, 32'h3F800000);
        run("R10 pz_nz",     0,0,0,0, 0, 32'h00000000, 0, 32'h80000000);
        run("R10 neg order", 0,0,0,0, 0, 32'hC0000000, 0, 32'hBF800000);
        run("R10 neg pos",   0,0,0,0, 0, 32'hBF800000, 0, 32'h3F800000);
        run("R9 dbl halves", 1,0,0,0, 32'h3FF00000, 32'h1, 32'h3FF00000, 32'h0);
        run("R9 dbl lt",     1,0,0,0, 32'h3FF00000, 0, 32'h40000000, 0);
        run("R9 sp hi ignored", 0,0,0,0, 32'hFFFFFFFF, 32'h3F800000, 32'h0, 32'h3F800000);
        run("R7 zero gt",    0,1,0,0, 0, 32'h3F800000, 0, 32'hC0000000);
        run("R7 zero lt",    0,1,0,0, 0, 32'hBF800000, 0, 32'h7FC00000);
        run("R7 zero eq dbl",1,1,0,0, 32'h80000000, 0, 32'h40000000, 0);
        run("R8 ftz eq",     0,0,0,1, 0, 32'h00000001, 0, 32'h80000000);
        run("R8 noftz gt",   0,0,0,0, 0, 32'h00000001, 0, 32'h80000000);
        run("R8 ftz dbl",    1,1,0,1, 32'h80000000, 32'h5, 0, 0);
        run("R4 inf vs 1",   0,0,0,0, 0, 32'h7F800000, 0, 32'h3F800000);
        run("R4 R5 qnan quiet", 0,0,0,0, 0, 32'h7FC00000, 0, 32'h3F800000);
        check("R5 qnan no inv", {31'd0, inv_op}, 32'd0);
        run("R5 snan quiet", 0,0,0,0, 0, 32'h3F800000, 0, 32'h7F800001);
        check("R5 snan inv", {31'd0, inv_op}, 32'd1);
        // R11 hold: idle cycle
        held = {flag_n, flag_z, flag_c, flag_v};
        @(posedge clk); #1;
        check("R11 idle valid", {31'd0, out_valid}, 32'd0);
        check("R11 hold", {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, held});
        run("R12 sticky", 0,0,0,0, 0, 32'h3F800000, 0, 32'h3F800000);
        check("R12 inv kept", {31'd0, inv_op}, 32'd1);
        do_reset();
        run("R5 dbl qnan", 1,0,0,0, 32'h7FF80000, 0, 32'h3FF00000, 0);
        check("R5 dbl qnan no inv", {31'd0, inv_op}, 32'd0);
        run("R5 dbl snan", 1,0,0,0, 32'h3FF00000, 0, 32'h7FF00000, 32'h1);
        check("R5 dbl snan inv", {31'd0, inv_op}, 32'd1);
        do_reset();
        run("R6 sig qnan", 0,0,1,0, 0, 32'h7FC00000, 0, 32'h3F800000);
        check("R6 sig inv", {31'd0, inv_op}, 32'd1);
        do_reset();
        run("R6 sig ordered", 1,0,1,0, 32'h40000000, 0, 32'h3FF00000, 0);
        check("R6 sig ordered no inv", {31'd0, inv_op}, 32'd0);

        for (int i = 0; i < 600; i++) begin
            logic [63:0] a, b;
            logic d, z, s, f;
            int k, sb;
            if (i % 40 == 0) do_reset();
            d = 1'($urandom % 2); z = ($urandom % 8) == 0;
            s = 1'($urandom % 2); f = 1'($urandom % 2);
            a = {$urandom, $urandom}; b = {$urandom, $urandom};
            sb = d ? 63 : 31;
            k = $urandom % 6;
            case (k)
                1: b = a;
                2: begin b = a; b[sb] = ~b[sb]; end
                3: begin b = a; b[0] = ~b[0]; end
                4: if (d) a[62:52] = '0; else a[30:23] = '0;
                5: if (d) a[62:52] = '1; else a[30:23] = '1;
                default: ;
            endcase
            run("R1 R2 R3 random", d, z, s, f, a[63:32], a[31:0], b[63:32], b[31:0]);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule